// File: doc/BRIEF.md
# Display Controller Register and Interrupt Block

This block is the software-visible register set of a display controller. It sits on a 32-bit memory-mapped request/response port and holds the controller's global control word, configuration, background and colour-key values, video timing words, panel dimensions and the setup of the graphics layer. Hardware elsewhere in the controller reads these values. Only the two panel enables are brought out as pins here, because they are the only fields this block decodes.

The block also owns a level interrupt. Event pulses from the display pipeline set bits in a status register. Software clears those bits by writing ones to them. The interrupt pin is high while any status bit is also enabled. A soft-reset bit in the system configuration word returns every register to its reset value in a single cycle.

Each request is a single cycle, and there is no back-pressure: `req_valid` is accepted on every clock edge. The response appears exactly one cycle later on `rsp_valid`. A request is rejected unless all four byte enables are set. A rejected request, or an access to an address with no register, writes nothing, returns zero and raises `rsp_err` with that response.

Top module: `dispc_regfile`

## Requirements
- R1: After reset, these reads hold: word 0x00 reads 0x20, word 0x08 reads 1, word 0x1C reads 0x161, the three size words 0x48/0x4C/0x50 read 0, and words 0x70 and 0x74 read 1. Every other register reads 0, and `irq`, `lcd_en` and `dig_en` are 0.
- R2: A request whose `req_be` is not 4'hF is rejected. It changes no register, its response data is 0, and `rsp_err` is 1.
- R3: A request to an address with no register, or with `req_addr[1:0]` not zero, returns data 0 with `rsp_err` = 1. A request to a mapped address returns `rsp_err` = 0.
- R4: Bit n of `evt_set` sets status bit n of word 0x0C. A write to 0x0C clears the status bits written as 1 and leaves the others unchanged. If an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R5: The interrupt enable word 0x10 keeps only its low 16 bits. `irq` is 1 exactly when (status AND enable) is nonzero, and it changes in the cycle after the write or event that caused the change.
- R6: The control word 0x14 stores value AND 0x07FF9FFF. Bit 0 drives `lcd_en` and bit 1 drives `dig_en`.
- R7: Writing word 0x04 with bit 1 set returns every register to its R1 value in that cycle and clears status and enable. Word 0x04 itself stores value AND 0x301B. Events that arrive in the same cycle as the soft reset are dropped.
- R8: The size words 0x48 (digital), 0x4C (LCD) and 0x50 (graphics layer) hold two fields stored as the count minus one: bits 10:0 (width) and bits 26:16 (height). All other bits read 0.
- R9: The colour words 0x20..0x2C keep 24 bits. The line-number word 0x30 keeps 11 bits, the configuration word 0x18 keeps 14 bits, and the capability word 0x1C keeps 10 bits.
- R10: The timing words use these masks: 0x38 and 0x3C use 0x0FF0FF3F, 0x40 uses 0x0003FFFF, and 0x44 uses 0x00FF00FF.
- R11: Four words are read-only and ignore writes: 0x00 reads 0x20, 0x08 reads 1, the line-status word 0x34 reads 0x7FF, and the graphics FIFO status word 0x6C reads 256.
- R12: The graphics words store as follows. The position word 0x54 keeps bits 10:0 and 26:16. The attribute word 0x64 keeps 11 bits, and the threshold word 0x68 uses mask 0x01FF01FF. The two base words 0x58/0x5C, the table base 0x60, the row and pixel increments 0x70/0x74 and the window skip 0x78 keep all 32 bits.
- R13: `rsp_valid` is 1 in the cycle after each accepted request and 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle (always accepted) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_be | input | 4 | Byte enables; only 4'hF is accepted |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data (0 for writes and errors) |
| rsp_err | output | 1 | Request was rejected or unmapped |
| evt_set | input | IRQ_W | Event pulses that set status bits (bit 0 = frame done) |
| irq | output | 1 | Level interrupt |
| lcd_en | output | 1 | LCD panel output enable |
| dig_en | output | 1 | Digital panel output enable |

## Verification
The bench targets the corners where a register block usually goes wrong:
- Same-cycle priority. An event and a clear aimed at the same status bit arrive together. A design that lets the clear win loses a frame-done event and leaves `irq` low.
- Partial-width writes. A design that ignores the byte enables corrupts the colour word.
- Masks and minus-one storage. Every mask and minus-one field is written with all ones and with mixed patterns. An off-by-one in the size storage shows up as a readback one count away from what was written.
- Soft reset. The bench checks that soft reset restores non-zero reset values such as the capability word and the increments, while the system configuration word keeps its own masked write. A design that reset it after the write, or cleared everything to zero, fails these reads.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  localparam int DATA_W = 32;

  // Word indices (byte offset / 4)
  localparam int W_ID      = 0;
  localparam int W_SYSCFG  = 1;
  localparam int W_SYSSTAT = 2;
  localparam int W_ISTAT   = 3;
  localparam int W_IEN     = 4;
  localparam int W_CTRL    = 5;
  localparam int W_CONFIG  = 6;
  localparam int W_CAPS    = 7;
  localparam int W_BG0     = 8;
  localparam int W_BG1     = 9;
  localparam int W_KEY0    = 10;
  localparam int W_KEY1    = 11;
  localparam int W_LINE    = 12;
  localparam int W_LSTAT   = 13;
  localparam int W_TIMH    = 14;
  localparam int W_TIMV    = 15;
  localparam int W_POL     = 16;
  localparam int W_DIV     = 17;
  localparam int W_SZDIG   = 18;
  localparam int W_SZLCD   = 19;
  localparam int W_SZGFX   = 20;
  localparam int W_POS     = 21;
  localparam int W_BASE0   = 22;
  localparam int W_BASE1   = 23;
  localparam int W_TABLE   = 24;
  localparam int W_ATTR    = 25;
  localparam int W_THR     = 26;
  localparam int W_FIFO    = 27;
  localparam int W_ROW     = 28;
  localparam int W_PIX     = 29;
  localparam int W_SKIP    = 30;

  typedef enum logic [2:0] {
    KIND_NONE,
    KIND_PLAIN,
    KIND_CONST,
    KIND_SIZE,
    KIND_ISTAT,
    KIND_IEN
  } word_kind_e;

  function automatic word_kind_e word_kind(input int w);
    case (w)
      W_ID, W_SYSSTAT, W_LSTAT, W_FIFO: word_kind = KIND_CONST;
      W_ISTAT:                          word_kind = KIND_ISTAT;
      W_IEN:                            word_kind = KIND_IEN;
      W_SZDIG, W_SZLCD, W_SZGFX:        word_kind = KIND_SIZE;
      W_SYSCFG, W_CTRL, W_CONFIG, W_CAPS,
      W_BG0, W_BG1, W_KEY0, W_KEY1, W_LINE,
      W_TIMH, W_TIMV, W_POL, W_DIV, W_POS,
      W_BASE0, W_BASE1, W_TABLE, W_ATTR, W_THR,
      W_ROW, W_PIX, W_SKIP:             word_kind = KIND_PLAIN;
      default:                          word_kind = KIND_NONE;
    endcase
  endfunction

  // Bits a write keeps, per plain word
  function automatic logic [DATA_W-1:0] word_mask(input int w);
    case (w)
      W_SYSCFG:                     word_mask = 32'h0000_301B;
      W_CTRL:                       word_mask = 32'h07FF_9FFF;
      W_CONFIG:                     word_mask = 32'h0000_3FFF;
      W_CAPS:                       word_mask = 32'h0000_03FF;
      W_BG0, W_BG1, W_KEY0, W_KEY1: word_mask = 32'h00FF_FFFF;
      W_LINE:                       word_mask = 32'h0000_07FF;
      W_TIMH, W_TIMV:               word_mask = 32'h0FF0_FF3F;
      W_POL:                        word_mask = 32'h0003_FFFF;
      W_DIV:                        word_mask = 32'h00FF_00FF;
      W_POS:                        word_mask = 32'h07FF_07FF;
      W_ATTR:                       word_mask = 32'h0000_07FF;
      W_THR:                        word_mask = 32'h01FF_01FF;
      default:                      word_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  // Reset value, also the fixed value of constant words
  function automatic logic [DATA_W-1:0] word_rst(input int w);
    case (w)
      W_ID:         word_rst = 32'h0000_0020;
      W_SYSSTAT:    word_rst = 32'h0000_0001;
      W_CAPS:       word_rst = 32'h0000_0161;
      W_LSTAT:      word_rst = 32'h0000_07FF;
      W_FIFO:       word_rst = 32'h0000_0100;
      W_ROW, W_PIX: word_rst = 32'h0000_0001;
      default:      word_rst = '0;
    endcase
  endfunction

endpackage

// File: rtl/dpc_field_reg.sv
module dpc_field_reg #(
  parameter logic [31:0] MASK = 32'hFFFF_FFFF,
  parameter logic [31:0] RST  = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        we,
  input  logic [31:0] wdata,
  output logic [31:0] q
);
  // A write to this word wins over a soft reset in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= RST;
    else if (we)       q <= wdata & MASK;
    else if (soft_rst) q <= RST;
  end
endmodule

// File: rtl/dpc_size_reg.sv
module dpc_size_reg #(
  parameter int FW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          we,
  input  logic [FW-1:0] wdata_x,
  input  logic [FW-1:0] wdata_y,
  output logic [31:0]   rdata
);
  localparam int CW = FW + 1;
  localparam logic [CW-1:0] ONE = CW'(1);

  // Counts are kept as true counts (field + 1)
  logic [CW-1:0] cnt_x, cnt_y;
  logic [CW-1:0] fx, fy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_x <= ONE;
      cnt_y <= ONE;
    end else if (soft_rst) begin
      cnt_x <= ONE;
      cnt_y <= ONE;
    end else if (we) begin
      cnt_x <= {1'b0, wdata_x} + ONE;
      cnt_y <= {1'b0, wdata_y} + ONE;
    end
  end

  always_comb begin
    fx = cnt_x - ONE;
    fy = cnt_y - ONE;
    rdata = '0;
    rdata[FW-1:0]  = fx[FW-1:0];
    rdata[16 +: FW] = fy[FW-1:0];
  end
endmodule

// File: rtl/dpc_irq_unit.sv
module dpc_irq_unit #(
  parameter int IRQ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic [IRQ_W-1:0] evt_set,
  input  logic             clr_we,
  input  logic [IRQ_W-1:0] clr_mask,
  input  logic             en_we,
  input  logic [IRQ_W-1:0] en_wdata,
  output logic [IRQ_W-1:0] status,
  output logic [IRQ_W-1:0] enable,
  output logic             irq
);
  logic [IRQ_W-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
    end else if (soft_rst) begin
      status <= '0;
      enable <= '0;
    end else begin
      // set after clear: an event beats a same-cycle clear
      status <= (status & ~clr_eff) | evt_set;
      if (en_we) enable <= en_wdata;
    end
  end

  assign irq = |(status & enable);
endmodule

// File: rtl/dispc_regfile.sv
module dispc_regfile
  import dpc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IRQ_W  = 16,
  parameter int SIZE_FW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  input  logic [IRQ_W-1:0]  evt_set,
  output logic              irq,
  output logic              lcd_en,
  output logic              dig_en
);
  localparam int WORD_AW   = ADDR_W - 2;
  localparam int NUM_WORDS = 2 ** WORD_AW;

  logic [WORD_AW-1:0] idx;
  logic               full_word, aligned, mapped, ok, wr_ok, soft_rst;
  logic [31:0]        rd_words [NUM_WORDS];
  logic [IRQ_W-1:0]   irq_status, irq_enable;

  assign idx       = req_addr[ADDR_W-1:2];
  assign full_word = (req_be == 4'hF);
  assign aligned   = (req_addr[1:0] == 2'b00);
  assign mapped    = aligned && (word_kind(int'(idx)) != KIND_NONE);
  assign ok        = full_word && mapped;
  assign wr_ok     = req_valid && req_write && ok;
  assign soft_rst  = wr_ok && (idx == WORD_AW'(W_SYSCFG)) && req_wdata[1];

  dpc_irq_unit #(.IRQ_W(IRQ_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .evt_set  (evt_set),
    .clr_we   (wr_ok && (idx == WORD_AW'(W_ISTAT))),
    .clr_mask (req_wdata[IRQ_W-1:0]),
    .en_we    (wr_ok && (idx == WORD_AW'(W_IEN))),
    .en_wdata (req_wdata[IRQ_W-1:0]),
    .status   (irq_status),
    .enable   (irq_enable),
    .irq      (irq)
  );

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam word_kind_e K = word_kind(w);
    if (K == KIND_PLAIN) begin : g_plain
      logic we_w;
      assign we_w = wr_ok && (idx == WORD_AW'(w));
      dpc_field_reg #(.MASK(word_mask(w)), .RST(word_rst(w))) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .we       (we_w),
        .wdata    (req_wdata),
        .q        (rd_words[w])
      );
    end else if (K == KIND_SIZE) begin : g_size
      logic we_w;
      assign we_w = wr_ok && (idx == WORD_AW'(w));
      dpc_size_reg #(.FW(SIZE_FW)) u_size (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .we       (we_w),
        .wdata_x  (req_wdata[SIZE_FW-1:0]),
        .wdata_y  (req_wdata[16 +: SIZE_FW]),
        .rdata    (rd_words[w])
      );
    end else if (K == KIND_CONST) begin : g_const
      assign rd_words[w] = word_rst(w);
    end else if (K == KIND_ISTAT) begin : g_istat
      assign rd_words[w] = 32'(irq_status);
    end else if (K == KIND_IEN) begin : g_ien
      assign rd_words[w] = 32'(irq_enable);
    end else begin : g_none
      assign rd_words[w] = '0;
    end
  end

  assign lcd_en = rd_words[W_CTRL][0];
  assign dig_en = rd_words[W_CTRL][1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && !ok;
      rsp_rdata <= (req_valid && !req_write && ok) ? rd_words[idx] : '0;
    end
  end
endmodule

// File: rtl/dispc_regfile_chk.sv
module dispc_regfile_chk #(
  parameter int IRQ_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [IRQ_W-1:0] evt_set,
  input logic             rsp_valid,
  input logic             rsp_err,
  input logic [31:0]      rsp_rdata,
  input logic             irq,
  input logic             lcd_en,
  input logic             dig_en
);
  assert_rsp_after_req_R13: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_spurious_rsp_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_err_data_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == 32'h0));
  assert_irq_rise_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past((evt_set != '0) || req_valid));
  assert_irq_fall_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(req_valid));
  assert_enables_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(lcd_en) && $stable(dig_en)));
endmodule

bind dispc_regfile dispc_regfile_chk #(.IRQ_W(IRQ_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .evt_set   (evt_set),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_rdata (rsp_rdata),
  .irq       (irq),
  .lcd_en    (lcd_en),
  .dig_en    (dig_en)
);

// File: tb/tb_dispc_regfile.sv
module tb_dispc_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [3:0]  req_be = 4'hF;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_err, irq, lcd_en, dig_en;
  logic [31:0] rsp_rdata;
  logic [15:0] evt_set = '0;

  int checks = 0, errors = 0;
  logic finished = 1'b0;

  always #5 clk = ~clk;

  dispc_regfile dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .evt_set(evt_set), .irq(irq), .lcd_en(lcd_en), .dig_en(dig_en)
  );

  typedef struct packed {
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{8'h14, 32'hFFFF_FFFF, 32'h07FF_9FFF},  // R6
    '{8'h18, 32'hFFFF_FFFF, 32'h0000_3FFF},  // R9
    '{8'h1C, 32'hFFFF_FFFF, 32'h0000_03FF},  // R9
    '{8'h20, 32'hFFFF_FFFF, 32'h00FF_FFFF},  // R9
    '{8'h2C, 32'hAABB_CCDD, 32'h00BB_CCDD},  // R9
    '{8'h30, 32'h0000_FFFF, 32'h0000_07FF},  // R9
    '{8'h38, 32'hFFFF_FFFF, 32'h0FF0_FF3F},  // R10
    '{8'h3C, 32'h1234_5678, 32'h0230_5638},  // R10
    '{8'h40, 32'hFFFF_FFFF, 32'h0003_FFFF},  // R10
    '{8'h44, 32'hFFFF_FFFF, 32'h00FF_00FF},  // R10
    '{8'h48, 32'hFFFF_FFFF, 32'h07FF_07FF},  // R8
    '{8'h4C, 32'h00EF_013F, 32'h00EF_013F},  // R8
    '{8'h50, 32'h1234_5678, 32'h0234_0678},  // R8
    '{8'h54, 32'hFFFF_FFFF, 32'h07FF_07FF},  // R12
    '{8'h58, 32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R12
    '{8'h60, 32'h1234_5678, 32'h1234_5678},  // R12
    '{8'h64, 32'hFFFF_FFFF, 32'h0000_07FF},  // R12
    '{8'h68, 32'hFFFF_FFFF, 32'h01FF_01FF},  // R12
    '{8'h70, 32'hFFFF_FFFE, 32'hFFFF_FFFE},  // R12
    '{8'h10, 32'hFFFF_FFFF, 32'h0000_FFFF}   // R5
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [7:0] a, input logic [31:0] d,
                        input logic [3:0] be, output logic [31:0] rd, output logic err);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0; req_be = 4'hF;
    chk("R13 rsp_valid", 32'(rsp_valid), 32'd1);
    rd = rsp_rdata;
    err = rsp_err;
  endtask

  task automatic wr32(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] rd; logic err;
    access(1'b1, a, d, 4'hF, rd, err);
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] rd; logic err;
    access(1'b0, a, 32'h0, 4'hF, rd, err);
    chk(tag, rd, exp);
    chk({tag, " err"}, 32'(err), 32'd0);
  endtask

  task automatic pulse(input logic [15:0] v);
    @(negedge clk); evt_set = v;
    @(negedge clk); evt_set = '0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd; logic err;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 lcd_en", 32'(lcd_en), 0);
    chk("R1 dig_en", 32'(dig_en), 0);
    chk("R13 idle rsp_valid", 32'(rsp_valid), 0);
    rd_chk("R1 id", 8'h00, 32'h20);
    rd_chk("R1 sysstat", 8'h08, 32'h1);
    rd_chk("R1 caps", 8'h1C, 32'h161);
    rd_chk("R1 size lcd", 8'h4C, 32'h0);
    rd_chk("R1 row inc", 8'h70, 32'h1);
    rd_chk("R1 pix inc", 8'h74, 32'h1);
    rd_chk("R1 ctrl", 8'h14, 32'h0);

    // table walk: write then read back masked value
    for (int i = 0; i < NV; i++) begin
      wr32(VEC[i].addr, VEC[i].wdata);
      rd_chk($sformatf("table[%0d] addr 0x%02h", i, VEC[i].addr), VEC[i].addr, VEC[i].exp);
    end
    chk("R6 lcd_en after table", 32'(lcd_en), 1);
    chk("R6 dig_en after table", 32'(dig_en), 1);
    chk("R5 irq no status", 32'(irq), 0);

    // R6 enable bit positions
    wr32(8'h14, 32'h1);
    chk("R6 lcd_en bit0", 32'(lcd_en), 1);
    chk("R6 dig_en bit0", 32'(dig_en), 0);
    wr32(8'h14, 32'h2);
    chk("R6 lcd_en bit1", 32'(lcd_en), 0);
    chk("R6 dig_en bit1", 32'(dig_en), 1);

    // R2 partial width
    access(1'b1, 8'h24, 32'h0012_3456, 4'h3, rd, err);
    chk("R2 partial write err", 32'(err), 1);
    rd_chk("R2 partial write ignored", 8'h24, 32'h0);
    access(1'b0, 8'h20, 32'h0, 4'h1, rd, err);
    chk("R2 partial read err", 32'(err), 1);
    chk("R2 partial read data", rd, 32'h0);

    // R3 unmapped / misaligned
    access(1'b0, 8'h7C, 32'h0, 4'hF, rd, err);
    chk("R3 unmapped err", 32'(err), 1);
    chk("R3 unmapped data", rd, 32'h0);
    access(1'b0, 8'h21, 32'h0, 4'hF, rd, err);
    chk("R3 misaligned err", 32'(err), 1);
    chk("R3 misaligned data", rd, 32'h0);

    // R11 read-only words
    wr32(8'h34, 32'h0);
    rd_chk("R11 line status", 8'h34, 32'h7FF);
    wr32(8'h6C, 32'h0);
    rd_chk("R11 fifo status", 8'h6C, 32'h100);
    wr32(8'h00, 32'h0);
    rd_chk("R11 id", 8'h00, 32'h20);

    // R5 enable width, R4 set/clear
    wr32(8'h10, 32'h0001_0001);
    rd_chk("R5 enable low16", 8'h10, 32'h1);
    pulse(16'h0001);
    chk("R5 irq on event", 32'(irq), 1);
    rd_chk("R4 status bit0", 8'h0C, 32'h1);
    pulse(16'h0008);
    rd_chk("R4 status accumulate", 8'h0C, 32'h9);
    wr32(8'h0C, 32'h1);
    rd_chk("R4 w1c partial", 8'h0C, 32'h8);
    chk("R5 irq after clear", 32'(irq), 0);
    // same-cycle set and clear of bit 0
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h0C; req_wdata = 32'h9; req_be = 4'hF;
    evt_set = 16'h0001;
    @(negedge clk);
    req_valid = 1'b0; evt_set = '0;
    chk("R4 set wins irq", 32'(irq), 1);
    rd_chk("R4 set wins status", 8'h0C, 32'h1);

    // R13 no response without request
    @(negedge clk);
    chk("R13 idle after traffic", 32'(rsp_valid), 0);

    // R7 soft reset
    wr32(8'h14, 32'h3);
    pulse(16'h0004);
    wr32(8'h04, 32'hFFFF_FFFF);
    chk("R7 irq cleared", 32'(irq), 0);
    chk("R7 lcd_en cleared", 32'(lcd_en), 0);
    chk("R7 dig_en cleared", 32'(dig_en), 0);
    rd_chk("R7 sysconfig mask", 8'h04, 32'h301B);
    rd_chk("R7 caps restored", 8'h1C, 32'h161);
    rd_chk("R7 bg cleared", 8'h20, 32'h0);
    rd_chk("R7 size restored", 8'h48, 32'h0);
    rd_chk("R7 row inc restored", 8'h70, 32'h1);
    rd_chk("R7 status cleared", 8'h0C, 32'h0);
    rd_chk("R7 enable cleared", 8'h10, 32'h0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule